// File: doc/BRIEF.md
# Keyboard and Display Bus Port

This block sits on the data bus of an 8-bit processor and gives software a tiny character terminal: a keyboard data register, a keyboard status register and a display output register, each at a fixed address. Raw ASCII bytes arrive from a keyboard source with a valid strobe. They are normalised (line feed to carriage return, both delete codes to underscore, lower case folded to upper case) and a single pending key is held until software collects it. Two control bytes do not become keys. Instead they raise a one-cycle reset request or break request for the surrounding system.

Each byte that software writes to the display register is reduced to seven bits, remapped for a few codes and sent out as a valid/ready byte stream toward a terminal. The underscore code becomes a three-byte erase sequence. While any output byte is still waiting for the terminal, a wait signal tells the bus that further display writes are refused.

Top module: `kbd_disp_port`

## Requirements
- R1: A read of the status address (default 0xD011) returns 0x80 while a key is pending and 0x00 when none is.
- R2: A read of the data address (default 0xD010) while a key is pending returns the held key with bit 7 set, and the pending flag is clear from the next cycle.
- R3: A data-address read with no key pending returns 0x00 and changes nothing; a read of any other address returns 0x00 and leaves a pending key in place.
- R4: While a key is pending, every keyboard byte is ignored, control bytes included, so the held key is never overwritten.
- R5: Input 0x0A is held as 0x0D; inputs 0x7F and 0x08 are held as 0x5F; other codes outside a–z are held unchanged.
- R6: With case folding enabled (default), inputs 0x61 to 0x7A are held with bit 5 cleared; 0x7B is not folded.
- R7: Input 0x12 raises reset_req and input 0x02 raises break_req for exactly one cycle, in the cycle after the strobe; neither byte becomes a pending key.
- R8: A display write sends its low seven bits on dsp_byte with dsp_valid from the next cycle, except that 0x7F is sent as 0x40 and 0x0D as 0x0A; the byte stays stable until dsp_ready is seen.
- R9: A display write of 0x5F sends 0x08, 0x20, 0x08 in that order; bus_wait is high while any output byte is undelivered, and a display write made while bus_wait is high is dropped.
- R10: Synchronous reset clears the pending flag, the held key, the request pulses and the display output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| bus_wait | output | 1 | Display writes refused while high |
| kb_valid | input | 1 | Keyboard byte strobe |
| kb_byte | input | 8 | Raw keyboard byte |
| reset_req | output | 1 | One-cycle reset request |
| break_req | output | 1 | One-cycle break request |
| dsp_valid | output | 1 | Display byte valid |
| dsp_byte | output | 8 | Display byte |
| dsp_ready | input | 1 | Terminal accepts the display byte |

## Verification
Read data is combinational, so the bench samples bus_rdata one time step after it sets the address in the low clock phase, and the clearing effect of a data read is checked only after the following rising edge. A keyboard strobe is registered at one edge, so the pending key and the request pulses are checked in the low phase right after that edge, and the pulse is checked gone one cycle later. A display write shows on dsp_byte from the edge that takes the write; each later erase byte appears one edge after the previous one is taken with dsp_ready high, and the bench samples every byte in the low phase between those edges.

// File: rtl/kdp_pkg.sv
package kdp_pkg;
   localparam logic [7:0] CH_BS    = 8'h08;
   localparam logic [7:0] CH_LF    = 8'h0A;
   localparam logic [7:0] CH_CR    = 8'h0D;
   localparam logic [7:0] CH_SPACE = 8'h20;
   localparam logic [7:0] CH_AT    = 8'h40;
   localparam logic [7:0] CH_UNDER = 8'h5F;
   localparam logic [7:0] CH_DEL   = 8'h7F;
   localparam logic [7:0] CH_RESET = 8'h12;
   localparam logic [7:0] CH_BREAK = 8'h02;
   localparam logic [7:0] CH_LOW_A = 8'h61;
   localparam logic [7:0] CH_LOW_Z = 8'h7A;
   localparam logic [7:0] FLAG_MSB = 8'h80;
endpackage

// File: rtl/kdp_key_norm.sv
module kdp_key_norm
   import kdp_pkg::*;
#(
   parameter bit FOLD_CASE = 1'b1
) (
   input  logic [7:0] raw,
   output logic [7:0] key,
   output logic       is_reset,
   output logic       is_break
);
   logic [7:0] folded;

   generate
      if (FOLD_CASE) begin : g_fold
         always_comb begin
            if (raw >= CH_LOW_A && raw <= CH_LOW_Z) folded = raw & 8'hDF;
            else                                   folded = raw;
         end
      end else begin : g_nofold
         always_comb folded = raw;
      end
   endgenerate

   always_comb begin
      is_reset = (raw == CH_RESET);
      is_break = (raw == CH_BREAK);
      if (raw == CH_LF)                         key = CH_CR;
      else if (raw == CH_DEL || raw == CH_BS)   key = CH_UNDER;
      else                                      key = folded;
   end
endmodule

// File: rtl/kdp_key_hold.sv
module kdp_key_hold (
   input  logic       clk,
   input  logic       rst,
   input  logic       in_valid,
   input  logic [7:0] in_key,
   input  logic       in_reset,
   input  logic       in_break,
   input  logic       rd_clear,
   output logic       pend,
   output logic [7:0] key,
   output logic       reset_req,
   output logic       break_req
);
   logic accept;
   assign accept = in_valid & ~pend;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend      <= 1'b0;
         key       <= '0;
         reset_req <= 1'b0;
         break_req <= 1'b0;
      end else begin
         reset_req <= accept & in_reset;
         break_req <= accept & in_break;
         if (accept && !in_reset && !in_break) begin
            pend <= 1'b1;
            key  <= in_key;
         end else if (rd_clear) begin
            pend <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/kdp_disp_seq.sv
module kdp_disp_seq
   import kdp_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       wr_en,
   input  logic [7:0] wdata,
   input  logic       ready,
   output logic [7:0] out_byte,
   output logic       out_valid
);
   logic [7:0] low7;
   logic [7:0] mapped;
   logic [1:0] remain;

   always_comb begin
      low7 = wdata & 8'h7F;
      if (low7 == CH_DEL)     mapped = CH_AT;
      else if (low7 == CH_CR) mapped = CH_LF;
      else                    mapped = low7;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_byte  <= '0;
         out_valid <= 1'b0;
         remain    <= '0;
      end else if (out_valid) begin
         if (ready) begin
            if (remain == 2'd0) begin
               out_valid <= 1'b0;
            end else begin
               out_byte <= (remain == 2'd2) ? CH_SPACE : CH_BS;
               remain   <= remain - 2'd1;
            end
         end
      end else if (wr_en) begin
         out_valid <= 1'b1;
         if (mapped == CH_UNDER) begin
            out_byte <= CH_BS;
            remain   <= 2'd2;
         end else begin
            out_byte <= mapped;
            remain   <= 2'd0;
         end
      end
   end
endmodule

// File: rtl/kbd_disp_port.sv
module kbd_disp_port
   import kdp_pkg::*;
#(
   parameter int              ADDR_W        = 16,
   parameter logic [ADDR_W-1:0] KEY_DATA_ADDR = 16'hD010,
   parameter logic [ADDR_W-1:0] KEY_STAT_ADDR = 16'hD011,
   parameter logic [ADDR_W-1:0] DSP_ADDR      = 16'hD012,
   parameter bit              FOLD_CASE     = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              bus_wait,
   input  logic              kb_valid,
   input  logic [7:0]        kb_byte,
   output logic              reset_req,
   output logic              break_req,
   output logic              dsp_valid,
   output logic [7:0]        dsp_byte,
   input  logic              dsp_ready
);
   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("kbd_disp_port: ADDR_W too small");
      end
      if (KEY_DATA_ADDR == KEY_STAT_ADDR || KEY_DATA_ADDR == DSP_ADDR ||
          KEY_STAT_ADDR == DSP_ADDR) begin : g_bad_map
         $error("kbd_disp_port: register addresses must differ");
      end
   endgenerate

   logic [7:0] norm_key;
   logic       norm_reset, norm_break;
   logic       pend_q;
   logic [7:0] key_q;
   logic       hit_data, hit_stat, hit_dsp;
   logic       rd_clear, wr_en;

   assign hit_data = (bus_addr == KEY_DATA_ADDR);
   assign hit_stat = (bus_addr == KEY_STAT_ADDR);
   assign hit_dsp  = (bus_addr == DSP_ADDR);
   assign rd_clear = bus_rd & hit_data & pend_q;
   assign wr_en    = bus_wr & hit_dsp & ~dsp_valid;
   assign bus_wait = dsp_valid;

   kdp_key_norm #(.FOLD_CASE(FOLD_CASE)) u_norm (
      .raw(kb_byte), .key(norm_key), .is_reset(norm_reset), .is_break(norm_break)
   );

   kdp_key_hold u_hold (
      .clk(clk), .rst(rst), .in_valid(kb_valid), .in_key(norm_key),
      .in_reset(norm_reset), .in_break(norm_break), .rd_clear(rd_clear),
      .pend(pend_q), .key(key_q), .reset_req(reset_req), .break_req(break_req)
   );

   kdp_disp_seq u_disp (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(bus_wdata), .ready(dsp_ready),
      .out_byte(dsp_byte), .out_valid(dsp_valid)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (hit_stat)                 bus_rdata = pend_q ? FLAG_MSB : 8'h00;
         else if (hit_data && pend_q)  bus_rdata = key_q | FLAG_MSB;
      end
   end
endmodule

// File: rtl/kbd_disp_port_chk.sv
module kbd_disp_port_chk #(
   parameter int ADDR_W = 16,
   parameter logic [ADDR_W-1:0] KEY_DATA_ADDR = 16'hD010
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              kb_valid,
   input logic [7:0]        kb_byte,
   input logic              pend,
   input logic [7:0]        key,
   input logic              reset_req,
   input logic              break_req,
   input logic              dsp_valid,
   input logic [7:0]        dsp_byte,
   input logic              dsp_ready
);
   logic data_rd;
   assign data_rd = bus_rd && (bus_addr == KEY_DATA_ADDR);

   assert_read_clears_R2: assert property (@(posedge clk) disable iff (rst)
      (data_rd && pend) |=> !pend);

   assert_no_overwrite_R4: assert property (@(posedge clk) disable iff (rst)
      (pend && !data_rd) |=> (pend && $stable(key)));

   assert_reset_pulse_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(reset_req) |-> $past(kb_valid && kb_byte == 8'h12 && !pend));

   assert_one_request_R7: assert property (@(posedge clk) disable iff (rst)
      $onehot0({reset_req, break_req}));

   assert_hold_output_R8: assert property (@(posedge clk) disable iff (rst)
      (dsp_valid && !dsp_ready) |=> (dsp_valid && $stable(dsp_byte)));

   assert_seven_bit_R8: assert property (@(posedge clk) disable iff (rst)
      dsp_valid |-> !dsp_byte[7]);
endmodule

bind kbd_disp_port kbd_disp_port_chk #(.ADDR_W(ADDR_W), .KEY_DATA_ADDR(KEY_DATA_ADDR)) u_chk (
   .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
   .kb_valid(kb_valid), .kb_byte(kb_byte), .pend(pend_q), .key(key_q),
   .reset_req(reset_req), .break_req(break_req),
   .dsp_valid(dsp_valid), .dsp_byte(dsp_byte), .dsp_ready(dsp_ready)
);

// File: tb/test_kbd_disp_port.sv
module test_kbd_disp_port;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] bus_addr = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        bus_wait;
   logic        kb_valid = 1'b0;
   logic [7:0]  kb_byte = '0;
   logic        reset_req, break_req, dsp_valid;
   logic [7:0]  dsp_byte;
   logic        dsp_ready = 1'b0;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   localparam logic [15:0] A_DATA = 16'hD010, A_STAT = 16'hD011, A_DSP = 16'hD012;

   always #5 clk = ~clk;

   kbd_disp_port i_kbd_disp_port (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait),
      .kb_valid(kb_valid), .kb_byte(kb_byte), .reset_req(reset_req),
      .break_req(break_req), .dsp_valid(dsp_valid), .dsp_byte(dsp_byte),
      .dsp_ready(dsp_ready)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic key_in(input logic [7:0] b);
      @(negedge clk); kb_valid = 1'b1; kb_byte = b;
      @(negedge clk); kb_valid = 1'b0;
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic bus_write(input logic [7:0] d);
      @(negedge clk); bus_addr = A_DSP; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic expect_out(input string req, input logic [7:0] b);
      check(req, {7'd0, dsp_valid}, 8'd1);
      check(req, dsp_byte, b);
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      logic [7:0] d;
      check("R10 valid", {7'd0, dsp_valid}, 8'd0);
      check("R10 wait", {7'd0, bus_wait}, 8'd0);
      check("R10 req", {6'd0, reset_req, break_req}, 8'd0);
      bus_read(A_STAT, d); check("R10 status", d, 8'h00);
   endtask

   task automatic t_key_read();
      logic [7:0] d;
      key_in(8'h41);
      bus_read(A_STAT, d); check("R1 status pending", d, 8'h80);
      bus_read(A_DATA, d); check("R2 data", d, 8'hC1);
      bus_read(A_STAT, d); check("R2 cleared", d, 8'h00);
      bus_read(A_DATA, d); check("R3 empty data", d, 8'h00);
      bus_read(A_STAT, d); check("R3 still empty", d, 8'h00);
      key_in(8'h33);
      bus_read(16'hD013, d); check("R3 unmapped", d, 8'h00);
      bus_read(16'h0000, d); check("R3 unmapped low", d, 8'h00);
      bus_read(A_STAT, d); check("R3 key kept", d, 8'h80);
      bus_read(A_DATA, d); check("R5 plain digit", d, 8'hB3);
   endtask

   task automatic t_no_overwrite();
      logic [7:0] d;
      key_in(8'h41);
      key_in(8'h42);
      key_in(8'h12);
      check("R4 no reset while pending", {7'd0, reset_req}, 8'd0);
      bus_read(A_DATA, d); check("R4 first key kept", d, 8'hC1);
      bus_read(A_STAT, d); check("R4 second dropped", d, 8'h00);
   endtask

   task automatic t_translate();
      logic [7:0] d;
      key_in(8'h0A); bus_read(A_DATA, d); check("R5 LF", d, 8'h8D);
      key_in(8'h7F); bus_read(A_DATA, d); check("R5 DEL", d, 8'hDF);
      key_in(8'h08); bus_read(A_DATA, d); check("R5 BS", d, 8'hDF);
      key_in(8'h71); bus_read(A_DATA, d); check("R6 fold q", d, 8'hD1);
      key_in(8'h61); bus_read(A_DATA, d); check("R6 fold a", d, 8'hC1);
      key_in(8'h7A); bus_read(A_DATA, d); check("R6 fold z", d, 8'hDA);
      key_in(8'h7B); bus_read(A_DATA, d); check("R6 brace kept", d, 8'hFB);
   endtask

   task automatic t_control();
      logic [7:0] d;
      key_in(8'h12);
      check("R7 reset pulse", {6'd0, reset_req, break_req}, 8'h02);
      @(negedge clk);
      check("R7 reset ends", {6'd0, reset_req, break_req}, 8'h00);
      key_in(8'h02);
      check("R7 break pulse", {6'd0, reset_req, break_req}, 8'h01);
      @(negedge clk);
      check("R7 break ends", {6'd0, reset_req, break_req}, 8'h00);
      bus_read(A_STAT, d); check("R7 not latched", d, 8'h00);
   endtask

   task automatic t_display();
      dsp_ready = 1'b0;
      bus_write(8'hC1);
      check("R8 valid", {7'd0, dsp_valid}, 8'd1);
      check("R8 masked", dsp_byte, 8'h41);
      @(negedge clk); @(negedge clk);
      check("R8 held", dsp_byte, 8'h41);
      check("R9 wait high", {7'd0, bus_wait}, 8'd1);
      dsp_ready = 1'b1;
      @(negedge clk);
      check("R8 drained", {7'd0, dsp_valid}, 8'd0);
      bus_write(8'h7F); expect_out("R8 DEL to @", 8'h40);
      bus_write(8'h0D); expect_out("R8 CR to LF", 8'h0A);
      check("R8 idle", {7'd0, dsp_valid}, 8'd0);
   endtask

   task automatic t_erase();
      dsp_ready = 1'b1;
      bus_write(8'h5F);
      check("R9 wait", {7'd0, bus_wait}, 8'd1);
      expect_out("R9 erase 1", 8'h08);
      expect_out("R9 erase 2", 8'h20);
      expect_out("R9 erase 3", 8'h08);
      check("R9 done", {7'd0, dsp_valid}, 8'd0);
      dsp_ready = 1'b0;
      bus_write(8'hDF);
      bus_write(8'h41);
      dsp_ready = 1'b1;
      expect_out("R9 blocked 1", 8'h08);
      expect_out("R9 blocked 2", 8'h20);
      expect_out("R9 blocked 3", 8'h08);
      check("R9 write dropped", {7'd0, dsp_valid}, 8'd0);
   endtask

   task automatic t_sync_reset();
      logic [7:0] d;
      key_in(8'h41);
      dsp_ready = 1'b0;
      bus_write(8'h42);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      check("R10 out cleared", {7'd0, dsp_valid}, 8'd0);
      bus_read(A_STAT, d); check("R10 pend cleared", d, 8'h00);
      bus_read(A_DATA, d); check("R10 data cleared", d, 8'h00);
      dsp_ready = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset_state();
      t_key_read();
      t_no_overwrite();
      t_translate();
      t_control();
      t_display();
      t_erase();
      t_sync_reset();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule